// File: doc/BRIEF.md
# 3x3 Streaming Convolution Filter

This block applies a programmable 3x3 convolution to a grayscale video stream. Input pixels are 8-bit unsigned samples that arrive in raster order on a valid/ready stream, one frame at a time, with no gaps between lines. For each input pixel the block produces exactly one output pixel on a second valid/ready stream. The output pixel is built from the nine neighbours of the matching input position, each weighted by a signed coefficient. Pixels that fall outside the frame take the value of the nearest edge pixel, so the output frame has the same size as the input frame.

The nine coefficients and an enable flag are set through a small write-only register port. Coefficient writes always land in shadow copies. The shadow copies are moved into the working set when the first pixel of the next frame is taken. A frame starts only while the enable flag is set. Once a frame has started it always runs to its end. Two line memories hold the two previous lines. After the last input pixel, the final output line is produced from those memories without any further input. Output backpressure freezes the whole pipeline, and no data is lost.

Top module: `conv3x3_stream`

## Requirements
- R1: Each output pixel equals the sum over the 3x3 neighbourhood of pixel times coefficient, computed at full precision. The sum has 64 added, is shifted arithmetically right by 7, and is then limited to 0..255.
- R2: A neighbour outside the frame takes the value of the nearest pixel in the frame, both in rows and in columns. Each input frame of IMG_W x IMG_H pixels yields exactly IMG_W x IMG_H output pixels in raster order.
- R3: m_sop is high on the first output pixel of a frame only, and m_eop is high on the last output pixel only. Both are asserted only together with m_valid.
- R4: While m_valid is high and m_ready is low, m_data, m_sop and m_eop hold their values. Every result is delivered exactly once.
- R5: An input pixel is consumed only in a cycle where both s_valid and s_ready are high. s_ready is low while the output is stalled. Idle cycles on s_valid do not change any result.
- R6: Register offsets 0..8 hold the coefficients in row-major order. Offset 0 is the upper-left neighbour, offset 4 is the centre and offset 8 is the lower-right. Each coefficient is a 9-bit two's-complement value with 7 fraction bits, so 128 means 1.0 and -128 means -1.0. Bit 0 at offset 9 is the enable flag.
- R7: Coefficient writes made while a frame is running do not affect that frame. They take effect from the next frame onward.
- R8: While the enable flag is clear and no frame is running, s_ready stays low and no pixel is consumed. Clearing the flag during a frame still lets that frame finish.
- R9: After reset, m_valid and s_ready are low, all coefficients are zero and the enable flag is clear.
- R10: A negative weighted sum gives output 0, and a sum above 255 after rounding gives output 255.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through an internal synchroniser |
| s_valid | input | 1 | Input pixel is present |
| s_ready | output | 1 | Block takes the input pixel this cycle |
| s_data | input | 8 | Input pixel, unsigned grayscale |
| m_valid | output | 1 | Output pixel is present |
| m_ready | input | 1 | Receiver takes the output pixel this cycle |
| m_data | output | 8 | Output pixel, unsigned grayscale |
| m_sop | output | 1 | First output pixel of a frame |
| m_eop | output | 1 | Last output pixel of a frame |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register offset |
| cfg_wdata | input | 9 | Register write value |

## Verification
The checker assumes that every input frame is complete. The output counter that ties m_sop and m_eop to pixel positions is only meaningful if each frame delivers all IMG_W x IMG_H pixels. The bench therefore always sends whole frames. The checker also assumes that configuration writes never collide with the cycle that takes a frame's first pixel. The bench issues mid-frame writes only after the frame is well under way, and issues other writes only while the block is idle.

// File: rtl/conv3_pkg.sv
`timescale 1ns/1ps
package conv3_pkg;
  localparam int PIX_W     = 8;
  localparam int COEF_W    = 9;
  localparam int COEF_FRAC = 7;
  localparam int TAPS      = 9;
  localparam int CFG_AW    = 4;
  localparam int EN_SLOT   = 9;
  localparam int PROD_W    = PIX_W + 1 + COEF_W;
  localparam int ACC_W     = PROD_W + 4;

  typedef logic [PIX_W-1:0]         pix_t;
  typedef logic signed [COEF_W-1:0] coef_t;
  typedef logic signed [PROD_W-1:0] prod_t;
  typedef logic signed [ACC_W-1:0]  acc_t;

  // Round half up at the binary point, then saturate into the pixel range.
  function automatic pix_t round_clamp(input acc_t sum);
    acc_t shifted;
    shifted = (sum + acc_t'(1 <<< (COEF_FRAC - 1))) >>> COEF_FRAC;
    if (shifted < acc_t'(0))
      return '0;
    else if (shifted > acc_t'((1 << PIX_W) - 1))
      return '1;
    else
      return shifted[PIX_W-1:0];
  endfunction
endpackage

// File: rtl/conv3_coef_regs.sv
`timescale 1ns/1ps
module conv3_coef_regs
  import conv3_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [COEF_W-1:0] cfg_wdata,
  input  logic              load,
  output coef_t             coef_o [TAPS],
  output logic              run_en
);
  logic en_q, en_d;

  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    logic  hit;
    coef_t shadow_q, shadow_d;
    coef_t active_q, active_d;

    assign hit      = cfg_we && (cfg_addr == CFG_AW'(k));
    assign shadow_d = hit  ? coef_t'(cfg_wdata) : shadow_q;
    assign active_d = load ? shadow_q : active_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shadow_q <= '0;
        active_q <= '0;
      end else begin
        shadow_q <= shadow_d;
        active_q <= active_d;
      end
    end

    assign coef_o[k] = active_q;
  end

  always_comb begin
    en_d = en_q;
    if (cfg_we && (cfg_addr == CFG_AW'(EN_SLOT)))
      en_d = cfg_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_d;
  end

  assign run_en = en_q;
endmodule

// File: rtl/conv3_window.sv
`timescale 1ns/1ps
module conv3_window
  import conv3_pkg::*;
#(
  parameter int IMG_W = 320,
  parameter int IMG_H = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic run_en,
  input  logic s_valid,
  input  pix_t s_data,
  output logic s_ready,
  output logic frame_start,
  output pix_t win_o [TAPS],
  output logic win_valid,
  output logic win_sop,
  output logic win_eop
);
  localparam int COL_W  = $clog2(IMG_W + 1);
  localparam int ROW_W  = $clog2(IMG_H + 1);
  localparam int ADDR_W = $clog2(IMG_W);
  localparam logic [COL_W-1:0] PAD_COL   = COL_W'(IMG_W);
  localparam logic [ROW_W-1:0] FLUSH_ROW = ROW_W'(IMG_H);

  logic [COL_W-1:0]  col_q, col_d;
  logic [ROW_W-1:0]  row_q, row_d;
  logic              at_start, pad_step, flush_row, need_in, gate_ok, fire;
  logic [ADDR_W-1:0] lb_addr;
  pix_t              lb_top [IMG_W];
  pix_t              lb_mid [IMG_W];
  pix_t              mid_px, top_px, bot_px;
  pix_t              new_col [3];
  pix_t              win_q [3][3];
  pix_t              win_d [3][3];
  logic              wv_q, wv_d, sop_q, sop_d, eop_q, eop_d;

  // Step classification: fetch with input, flush fetch, or pad step.
  assign at_start  = (row_q == '0) && (col_q == '0);
  assign pad_step  = (col_q == PAD_COL);
  assign flush_row = (row_q == FLUSH_ROW);
  assign need_in   = !pad_step && !flush_row;
  assign gate_ok   = !at_start || run_en;
  assign s_ready   = adv && need_in && gate_ok;
  assign fire      = adv && gate_ok && (!need_in || s_valid);
  assign frame_start = fire && at_start;

  always_comb begin
    col_d = col_q;
    row_d = row_q;
    if (fire) begin
      if (pad_step) begin
        col_d = '0;
        row_d = flush_row ? '0 : row_q + 1'b1;
      end else begin
        col_d = col_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q <= '0;
      row_q <= '0;
    end else begin
      col_q <= col_d;
      row_q <= row_d;
    end
  end

  // Column fetch with vertical edge replication.
  assign lb_addr = pad_step ? '0 : col_q[ADDR_W-1:0];
  assign mid_px  = lb_mid[lb_addr];
  assign top_px  = (row_q == ROW_W'(1)) ? mid_px : lb_top[lb_addr];
  assign bot_px  = flush_row ? mid_px : s_data;
  assign new_col[0] = top_px;
  assign new_col[1] = mid_px;
  assign new_col[2] = bot_px;

  always_ff @(posedge clk) begin
    if (fire && need_in) begin
      lb_top[lb_addr] <= mid_px;
      lb_mid[lb_addr] <= s_data;
    end
  end

  // Window shift with horizontal edge replication.
  always_comb begin
    win_d = win_q;
    for (int r = 0; r < 3; r++) begin
      if (col_q == '0) begin
        win_d[r][0] = new_col[r];
        win_d[r][1] = new_col[r];
        win_d[r][2] = new_col[r];
      end else begin
        win_d[r][0] = win_q[r][1];
        win_d[r][1] = win_q[r][2];
        win_d[r][2] = pad_step ? win_q[r][2] : new_col[r];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < 3; r++)
        for (int c = 0; c < 3; c++)
          win_q[r][c] <= '0;
    end else if (fire) begin
      win_q <= win_d;
    end
  end

  assign wv_d  = fire && (row_q != '0) && (col_q != '0);
  assign sop_d = fire && (row_q == ROW_W'(1)) && (col_q == COL_W'(1));
  assign eop_d = fire && flush_row && pad_step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wv_q  <= 1'b0;
      sop_q <= 1'b0;
      eop_q <= 1'b0;
    end else if (adv) begin
      wv_q  <= wv_d;
      sop_q <= sop_d;
      eop_q <= eop_d;
    end
  end

  for (genvar r = 0; r < 3; r++) begin : g_row
    for (genvar c = 0; c < 3; c++) begin : g_col
      assign win_o[r*3+c] = win_q[r][c];
    end
  end

  assign win_valid = wv_q;
  assign win_sop   = sop_q;
  assign win_eop   = eop_q;
endmodule

// File: rtl/conv3_mac.sv
`timescale 1ns/1ps
module conv3_mac
  import conv3_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  adv,
  input  pix_t  win_i [TAPS],
  input  coef_t coef_i [TAPS],
  input  logic  in_valid,
  input  logic  in_sop,
  input  logic  in_eop,
  output logic  out_valid,
  output pix_t  out_data,
  output logic  out_sop,
  output logic  out_eop
);
  prod_t prod_w [TAPS];
  acc_t  acc_sum;
  logic  pv_q, psop_q, peop_q;
  logic  ov_q, osop_q, oeop_q;
  pix_t  od_q;

  // Stage 1: nine products at full precision.
  for (genvar k = 0; k < TAPS; k++) begin : g_mul
    prod_t p_q, p_d;
    assign p_d = $signed({1'b0, win_i[k]}) * coef_i[k];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   p_q <= '0;
      else if (adv) p_q <= p_d;
    end
    assign prod_w[k] = p_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv_q   <= 1'b0;
      psop_q <= 1'b0;
      peop_q <= 1'b0;
    end else if (adv) begin
      pv_q   <= in_valid;
      psop_q <= in_sop;
      peop_q <= in_eop;
    end
  end

  // Stage 2: sum, round and saturate.
  always_comb begin
    acc_sum = '0;
    for (int k = 0; k < TAPS; k++)
      acc_sum = acc_sum + acc_t'(prod_w[k]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_q   <= 1'b0;
      osop_q <= 1'b0;
      oeop_q <= 1'b0;
      od_q   <= '0;
    end else if (adv) begin
      ov_q   <= pv_q;
      osop_q <= psop_q;
      oeop_q <= peop_q;
      od_q   <= round_clamp(acc_sum);
    end
  end

  assign out_valid = ov_q;
  assign out_data  = od_q;
  assign out_sop   = osop_q;
  assign out_eop   = oeop_q;
endmodule

// File: rtl/conv3x3_stream.sv
`timescale 1ns/1ps
module conv3x3_stream
  import conv3_pkg::*;
#(
  parameter int IMG_W = 320,
  parameter int IMG_H = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [PIX_W-1:0]  s_data,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [PIX_W-1:0]  m_data,
  output logic              m_sop,
  output logic              m_eop,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [COEF_W-1:0] cfg_wdata
);
  logic  rs_meta_q, rs_core_q;
  logic  adv, run_en, frame_start;
  logic  wv, wsop, weop;
  pix_t  win [TAPS];
  coef_t coef [TAPS];

  // Reset asserted at once, released on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta_q <= 1'b0;
      rs_core_q <= 1'b0;
    end else begin
      rs_meta_q <= 1'b1;
      rs_core_q <= rs_meta_q;
    end
  end

  assign adv = !m_valid || m_ready;

  conv3_coef_regs u_regs (
    .clk       (clk),
    .rst_n     (rs_core_q),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .load      (frame_start),
    .coef_o    (coef),
    .run_en    (run_en)
  );

  conv3_window #(.IMG_W(IMG_W), .IMG_H(IMG_H)) u_win (
    .clk         (clk),
    .rst_n       (rs_core_q),
    .adv         (adv),
    .run_en      (run_en),
    .s_valid     (s_valid),
    .s_data      (s_data),
    .s_ready     (s_ready),
    .frame_start (frame_start),
    .win_o       (win),
    .win_valid   (wv),
    .win_sop     (wsop),
    .win_eop     (weop)
  );

  conv3_mac u_mac (
    .clk       (clk),
    .rst_n     (rs_core_q),
    .adv       (adv),
    .win_i     (win),
    .coef_i    (coef),
    .in_valid  (wv),
    .in_sop    (wsop),
    .in_eop    (weop),
    .out_valid (m_valid),
    .out_data  (m_data),
    .out_sop   (m_sop),
    .out_eop   (m_eop)
  );
endmodule

// File: rtl/conv3x3_stream_chk.sv
`timescale 1ns/1ps
module conv3x3_stream_chk #(
  parameter int IMG_W = 320,
  parameter int IMG_H = 200
) (
  input logic       clk,
  input logic       rst_n,
  input logic       s_ready,
  input logic       m_valid,
  input logic       m_ready,
  input logic [7:0] m_data,
  input logic       m_sop,
  input logic       m_eop
);
  localparam int NPIX  = IMG_W * IMG_H;
  localparam int CNT_W = $clog2(NPIX);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NPIX - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             take;

  assign take = m_valid && m_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (take) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assert_hold_under_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_sop) && $stable(m_eop)));

  assert_no_input_while_stalled_R5: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> (!m_valid || m_ready));

  assert_markers_qualified_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (m_sop || m_eop) |-> m_valid);

  assert_sop_first_pixel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && m_sop) |-> (cnt_q == '0));

  assert_eop_last_pixel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && m_eop) |-> (cnt_q == LAST));

  assert_frame_size_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cnt_q == LAST) |-> m_eop);
endmodule

bind conv3x3_stream conv3x3_stream_chk #(.IMG_W(IMG_W), .IMG_H(IMG_H)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .s_ready (s_ready),
  .m_valid (m_valid),
  .m_ready (m_ready),
  .m_data  (m_data),
  .m_sop   (m_sop),
  .m_eop   (m_eop)
);

// File: tb/conv3x3_stream_bench.sv
`timescale 1ns/1ps
module conv3x3_stream_bench;
  localparam int W = 6;
  localparam int H = 4;
  localparam int N = W * H;
  localparam int NCASE = 6;
  localparam int LIMIT = 100000;
  // Each row: nine coefficients (row-major), pixel pattern, mode (bit0 input gaps, bit1 output stalls)
  localparam int CASES [NCASE][11] = '{
    '{   0,   0,   0,   0, 128,   0,   0,   0,   0, 0, 0 },
    '{  14,  14,  14,  14,  14,  14,  14,  14,  14, 1, 1 },
    '{   0, -64,   0, -64, 255, -64,   0, -64,   0, 2, 2 },
    '{ 128,   0,   0,   0,   0,   0,   0,   0,   0, 1, 3 },
    '{   0,   0,   0,   0,-128,   0,   0,   0,   0, 0, 0 },
    '{   0,   0,   0,   0,   0,   0,   0,   0, 128, 1, 2 }
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       s_valid = 1'b0;
  logic       s_ready;
  logic [7:0] s_data = '0;
  logic       m_valid;
  logic       m_ready = 1'b0;
  logic [7:0] m_data;
  logic       m_sop, m_eop;
  logic       cfg_we = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [8:0] cfg_wdata = '0;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int img [H][W];
  int kern [9];
  int expv [N];

  always #2.5 clk = ~clk;

  conv3x3_stream #(.IMG_W(W), .IMG_H(H)) u_conv3x3_stream (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_sop(m_sop), .m_eop(m_eop),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > LIMIT) begin
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, LIMIT);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  function automatic int clampi(input int v, input int lo, input int hi);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction

  // Reference: R1 rounding and saturation, R2 edge replication.
  function automatic int model(input int r, input int c);
    int sum = 0;
    int q;
    for (int dr = -1; dr <= 1; dr++)
      for (int dc = -1; dc <= 1; dc++)
        sum += kern[(dr+1)*3 + (dc+1)] * img[clampi(r+dr, 0, H-1)][clampi(c+dc, 0, W-1)];
    q = (sum + 64) >>> 7;
    return clampi(q, 0, 255);
  endfunction

  task automatic make_image(input int pat);
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++)
        case (pat)
          0:       img[r][c] = ((r*W + c) * 10) & 255;
          1:       img[r][c] = (r*37 + c*91 + r*c*53 + 13) & 255;
          default: img[r][c] = ((r + c) % 2 == 1) ? 255 : 0;
        endcase
  endtask

  task automatic build_expect();
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++)
        expv[r*W + c] = model(r, c);
  endtask

  task automatic cfg_write(input int addr, input int val);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_addr = 4'(addr);
    cfg_wdata = 9'(val);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // R6: offset k holds coefficient k in row-major order.
  task automatic write_kernel(input int kv [9]);
    for (int k = 0; k < 9; k++) cfg_write(k, kv[k]);
  endtask

  task automatic drive_frame(input bit gaps);
    bit hs;
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      if (gaps && (i % 3 == 1)) begin
        s_valid = 1'b0;
        repeat (2) @(negedge clk);
      end
      s_valid = 1'b1;
      s_data = 8'(img[i / W][i % W]);
      forever begin
        #1 hs = s_ready;
        @(negedge clk);
        if (hs) break;
      end
    end
    s_valid = 1'b0;
  endtask

  task automatic collect_frame(input bit stalls, input string req);
    int got = 0;
    int k = 0;
    @(negedge clk);
    while (got < N) begin
      m_ready = !(stalls && (k % 3 != 0));
      #1;
      if (m_valid && m_ready) begin
        check(m_data == 8'(expv[got]), req, m_data, expv[got]);
        check((m_sop == (got == 0)) && (m_eop == (got == N-1)), "R3 markers",
              {m_sop, m_eop}, {(got == 0), (got == N-1)});
        got++;
      end
      @(negedge clk);
      k++;
    end
    m_ready = 1'b0;
  endtask

  task automatic idle_probe(input string req);
    bit seen = 1'b0;
    @(negedge clk);
    s_valid = 1'b1;
    s_data = 8'h5a;
    m_ready = 1'b1;
    repeat (12) begin
      #1 if (s_ready || m_valid) seen = 1'b1;
      @(negedge clk);
    end
    s_valid = 1'b0;
    m_ready = 1'b0;
    check(!seen, req, seen, 0);
  endtask

  initial begin
    int kv [9];
    int kb [9];
    repeat (4) @(negedge clk);
    // R9: reset state
    check(!m_valid && !s_ready, "R9 outputs in reset", {m_valid, s_ready}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(!m_valid && !s_ready, "R9 outputs after reset", {m_valid, s_ready}, 0);
    // R8: enable clear at reset, so nothing is taken
    idle_probe("R8 disabled after reset");

    // R9: coefficients are zero after reset, so the first frame is all zero.
    for (int k = 0; k < 9; k++) kern[k] = 0;
    cfg_write(9, 1);
    make_image(1);
    build_expect();
    fork
      drive_frame(1'b0);
      collect_frame(1'b0, "R9 zero coefficients");
    join

    // Table of vectors: R1 R2 R4 R5 R6 R10
    for (int t = 0; t < NCASE; t++) begin
      for (int k = 0; k < 9; k++) begin
        kv[k] = CASES[t][k];
        kern[k] = CASES[t][k];
      end
      write_kernel(kv);
      make_image(CASES[t][9]);
      build_expect();
      fork
        drive_frame(CASES[t][10][0]);
        collect_frame(CASES[t][10][1], $sformatf("R1 R2 R5 R6 R10 case %0d", t));
      join
    end

    // R7 and R8: writes during a frame are deferred, and clearing enable lets the frame finish.
    for (int k = 0; k < 9; k++) begin
      kv[k] = (k == 4) ? 128 : 0;
      kb[k] = (k == 0) ? 128 : 0;
      kern[k] = kv[k];
    end
    write_kernel(kv);
    make_image(0);
    build_expect();
    fork
      drive_frame(1'b1);
      collect_frame(1'b0, "R7 old kernel kept mid-frame");
      begin
        repeat (14) @(negedge clk);
        for (int k = 0; k < 9; k++) begin
          cfg_we = 1'b1;
          cfg_addr = 4'(k);
          cfg_wdata = 9'(kb[k]);
          @(negedge clk);
        end
        cfg_addr = 4'd9;
        cfg_wdata = 9'd0;
        @(negedge clk);
        cfg_we = 1'b0;
      end
    join
    idle_probe("R8 enable cleared");
    cfg_write(9, 1);
    for (int k = 0; k < 9; k++) kern[k] = kb[k];
    build_expect();
    fork
      drive_frame(1'b0);
      collect_frame(1'b1, "R7 new kernel next frame");
    join

    repeat (10) @(negedge clk);
    check(!m_valid, "R2 no extra output", m_valid, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule